// File: doc/BRIEF.md
# BRR Block Decoder

This block expands compressed audio sample blocks into signed 16-bit PCM. Each block arrives as nine bytes on a byte stream with a valid/ready handshake. The first byte is a header that sets a left-shift amount, picks one of four fixed-coefficient predictors and carries two status bits. The next eight bytes hold sixteen signed 4-bit codes, two per byte. Each code is sign-extended and shifted left. The chosen predictor then adds a weighted mix of the two most recent outputs, and the result is clamped to 16 bits. The clamped value is the output sample, and it is also stored as history for the next code.

Samples leave on their own valid/ready stream. The sixteenth sample of a block is marked as the last one. On that sample the decoder also reports either a stop or a loop, taken from the header's status bits. A synchronous restart input clears the history and drops any partial block, so the next byte accepted is read as a header.

Control is a four-state machine:
- `ST_HEAD` accepts the header and moves to `ST_FETCH`.
- `ST_FETCH` accepts a data byte and moves to `ST_EMIT_HI`.
- `ST_EMIT_HI` offers the sample decoded from the high nibble. Once that sample is taken, it moves to `ST_EMIT_LO`.
- `ST_EMIT_LO` offers the sample decoded from the low nibble. Once that sample is taken, it returns to `ST_FETCH`, or to `ST_HEAD` after the eighth data byte.
- A restart forces `ST_HEAD` from any state.

Top module: `brr_block_decoder`

## Requirements
- R1: A block is one header byte followed by 8 data bytes. They produce 16 output samples: the high nibble (bits 7:4) of each data byte first, then its low nibble (bits 3:0). `out_last` is 1 only on the 16th sample.
- R2: Header fields are: shift = bits 7:4, filter select = bits 3:2, loop bit = bit 1, end bit = bit 0.
- R3: Each nibble is read as a two's-complement value from -8 to +7, written n. The value used by the filters is x = n * 2^shift.
- R4: Filter 0 gives y = x and uses no history.
- R5: Filter 1 gives y = x + h1 - (h1 >>> 4). Here h1 is the previous output, h2 the one before it, and >>> is an arithmetic (floor) right shift.
- R6: Filter 2 gives y = x + 2*h1 - ((3*h1) >>> 5) - h2 + (h2 >>> 4).
- R7: Filter 3 gives y = x + 2*h1 - ((13*h1) >>> 6) - h2 + ((3*h2) >>> 4).
- R8: y is clamped to the range -32768 to 32767 and the clamped value is output. The clamped value becomes the new h1 and the old h1 becomes h2. History carries over from one block into the next.
- R9: On the last sample of a block, `out_stop` = end & ~loop and `out_loop` = end & loop. Both are 0 on every other sample. When the end bit is 0, the loop bit has no effect.
- R10: One cycle after a restart, `in_ready` = 1 and `out_valid` = 0. History is then 0, and the next accepted byte is treated as a header.
- R11: After reset, `in_ready` = 1 and `out_valid` = 0. While `out_valid` is 1 and `out_ready` is 0, the offered sample and its flags stay unchanged. `in_ready` and `out_valid` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart: clears history and returns to header |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Decoder can accept a byte |
| in_data | input | 8 | Input byte (header or data) |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Sink accepts the sample |
| out_sample | output | 16 | Decoded signed PCM sample |
| out_last | output | 1 | Sample is the 16th of its block |
| out_stop | output | 1 | Block ends playback (with last sample) |
| out_loop | output | 1 | Block requests a loop (with last sample) |

## Verification
A wrong history value shows up as a wrong sample on the very next output of any filter-1/2/3 block. Because history carries over, the error keeps spreading through later samples. A slip in the nibble or byte count moves `out_last` and the stop/loop flags off the 16th sample, and every following header is misread. The reference model therefore compares every handshaken sample and flag against its expected values. It checks restart by running a history-dependent block straight after a block that was cut off mid-way.

// File: rtl/brr_pkg.sv
package brr_pkg;

    typedef enum logic [1:0] {
        ST_HEAD    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_EMIT_HI = 2'd2,
        ST_EMIT_LO = 2'd3
    } brr_state_e;

    // Header byte layout: [7:4] shift, [3:2] filter, [1] loop, [0] end
    typedef struct packed {
        logic [3:0] shift;
        logic [1:0] filt;
        logic       loop_f;
        logic       end_f;
    } brr_hdr_t;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;

endpackage

// File: rtl/brr_predictor.sv
module brr_predictor
    import brr_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic [NIB_W-1:0]           nibble,
    input  logic [3:0]                 shift,
    input  logic [1:0]                 filt,
    input  logic signed [SAMPLE_W-1:0] h1,
    input  logic signed [SAMPLE_W-1:0] h2,
    output logic signed [SAMPLE_W-1:0] sample
);
    localparam int ACC_W = SAMPLE_W + 8;
    localparam logic signed [ACC_W-1:0] MAXV = (ACC_W)'(2**(SAMPLE_W-1) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - (ACC_W)'(1);

    logic signed [ACC_W-1:0] nib_x, scaled, h1x, h2x, pred, total;

    always_comb begin
        nib_x  = {{(ACC_W-NIB_W){nibble[NIB_W-1]}}, nibble};
        scaled = nib_x <<< shift;
        h1x    = {{(ACC_W-SAMPLE_W){h1[SAMPLE_W-1]}}, h1};
        h2x    = {{(ACC_W-SAMPLE_W){h2[SAMPLE_W-1]}}, h2};
        unique case (filt)
            2'd0: pred = '0;
            2'd1: pred = h1x - (h1x >>> 4);
            2'd2: pred = (h1x <<< 1) - ((h1x + (h1x <<< 1)) >>> 5)
                       - h2x + (h2x >>> 4);
            2'd3: pred = (h1x <<< 1) - (((h1x <<< 3) + (h1x <<< 2) + h1x) >>> 6)
                       - h2x + ((h2x + (h2x <<< 1)) >>> 4);
            default: pred = '0;
        endcase
        total = scaled + pred;
        if (total > MAXV)
            sample = MAXV[SAMPLE_W-1:0];
        else if (total < MINV)
            sample = MINV[SAMPLE_W-1:0];
        else
            sample = total[SAMPLE_W-1:0];
    end
endmodule

// File: rtl/brr_history.sv
module brr_history #(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       adv,
    input  logic signed [SAMPLE_W-1:0] newest,
    output logic signed [SAMPLE_W-1:0] h1,
    output logic signed [SAMPLE_W-1:0] h2
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h1 <= '0;
            h2 <= '0;
        end else if (clr) begin
            h1 <= '0;
            h2 <= '0;
        end else if (adv) begin
            h2 <= h1;
            h1 <= newest;
        end
    end
endmodule

// File: rtl/brr_seq.sv
module brr_seq
    import brr_pkg::*;
#(
    parameter int DATA_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_last,
    output brr_hdr_t          hdr,
    output logic [NIB_W-1:0]  nibble,
    output logic              adv
);
    localparam int CNT_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(DATA_BYTES - 1);

    brr_state_e        state, state_nx;
    logic [BYTE_W-1:0] data_q;
    logic [CNT_W-1:0]  byte_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HEAD;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (restart) begin
            state_nx = ST_HEAD;
        end else begin
            unique case (state)
                ST_HEAD:    if (in_valid) state_nx = ST_FETCH;
                ST_FETCH:   if (in_valid) state_nx = ST_EMIT_HI;
                ST_EMIT_HI: if (out_ready) state_nx = ST_EMIT_LO;
                ST_EMIT_LO: if (out_ready)
                                state_nx = (byte_cnt == LAST_BYTE) ? ST_HEAD : ST_FETCH;
                default:    state_nx = ST_HEAD;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        nibble    = data_q[NIB_W-1:0];
        unique case (state)
            ST_HEAD:    in_ready = 1'b1;
            ST_FETCH:   in_ready = 1'b1;
            ST_EMIT_HI: begin
                out_valid = 1'b1;
                nibble    = data_q[BYTE_W-1:NIB_W];
            end
            ST_EMIT_LO: begin
                out_valid = 1'b1;
                out_last  = (byte_cnt == LAST_BYTE);
            end
            default: ;
        endcase
        adv = out_valid && out_ready && !restart;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr      <= '0;
            data_q   <= '0;
            byte_cnt <= '0;
        end else if (!restart) begin
            if (state == ST_HEAD && in_valid) begin
                hdr      <= brr_hdr_t'(in_data);
                byte_cnt <= '0;
            end
            if (state == ST_FETCH && in_valid)
                data_q <= in_data;
            if (state == ST_EMIT_LO && out_ready)
                byte_cnt <= byte_cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/brr_block_decoder.sv
module brr_block_decoder
    import brr_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int DATA_BYTES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [7:0]          in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                out_last,
    output logic                out_stop,
    output logic                out_loop
);
    brr_hdr_t                   hdr;
    logic [NIB_W-1:0]           nibble;
    logic                       adv;
    logic signed [SAMPLE_W-1:0] h1, h2, sample;

    brr_seq #(.DATA_BYTES(DATA_BYTES)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_last  (out_last),
        .hdr       (hdr),
        .nibble    (nibble),
        .adv       (adv)
    );

    brr_predictor #(.SAMPLE_W(SAMPLE_W)) pred_i (
        .nibble (nibble),
        .shift  (hdr.shift),
        .filt   (hdr.filt),
        .h1     (h1),
        .h2     (h2),
        .sample (sample)
    );

    brr_history #(.SAMPLE_W(SAMPLE_W)) hist_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (restart),
        .adv    (adv),
        .newest (sample),
        .h1     (h1),
        .h2     (h2)
    );

    assign out_sample = sample;
    assign out_stop   = out_last & hdr.end_f & ~hdr.loop_f;
    assign out_loop   = out_last & hdr.end_f & hdr.loop_f;
endmodule

// File: rtl/brr_block_decoder_chk.sv
module brr_block_decoder_chk #(
    parameter int SAMPLE_W   = 16,
    parameter int DATA_BYTES = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                restart,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [SAMPLE_W-1:0] out_sample,
    input logic                out_last,
    input logic                out_stop,
    input logic                out_loop
);
    localparam int SPB   = 2 * DATA_BYTES;
    localparam int SCN_W = $clog2(SPB) + 1;

    logic [SCN_W-1:0] smp_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            smp_cnt <= '0;
        else if (restart)
            smp_cnt <= '0;
        else if (out_valid && out_ready)
            smp_cnt <= (smp_cnt == SCN_W'(SPB - 1)) ? '0 : smp_cnt + SCN_W'(1);
    end

    AST_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (smp_cnt == SCN_W'(SPB - 1)))); // R1

    AST_FLAGS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stop || out_loop) |-> (out_valid && out_last)); // R9

    AST_STOP_LOOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_stop, out_loop})); // R9

    AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (in_ready && !out_valid)); // R10

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !restart) |=>
            (out_valid && $stable(out_sample) && $stable(out_last)
             && $stable(out_stop) && $stable(out_loop))); // R11

    AST_NO_BOTH_SIDES: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid)); // R11
endmodule

bind brr_block_decoder brr_block_decoder_chk #(
    .SAMPLE_W   (SAMPLE_W),
    .DATA_BYTES (DATA_BYTES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sample (out_sample),
    .out_last   (out_last),
    .out_stop   (out_stop),
    .out_loop   (out_loop)
);

// File: tb/brr_block_decoder_tb_top.sv
`timescale 1ns/1ps
module brr_block_decoder_tb_top;

    typedef struct {
        int s;
        bit last;
        bit stp;
        bit lp;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_sample;
    logic        out_last, out_stop, out_loop;

    int   errors = 0;
    int   checks = 0;
    int   ref_h1 = 0;
    int   ref_h2 = 0;
    int   seed = 12345;
    int   cyc = 0;
    logic [7:0] in_q[$];
    exp_t       exp_q[$];

    always #2.5 clk = ~clk;

    brr_block_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample),
        .out_last(out_last), .out_stop(out_stop), .out_loop(out_loop)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int next_byte();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 8'hFF;
    endfunction

    // Behavioural model of R3..R8
    function automatic int model(input int nib, input int sh, input int f);
        int n, x, y;
        n = (nib > 7) ? nib - 16 : nib;
        x = n * (1 << sh);
        case (f)
            0: y = x;
            1: y = x + ref_h1 - (ref_h1 >>> 4);
            2: y = x + 2*ref_h1 - ((3*ref_h1) >>> 5) - ref_h2 + (ref_h2 >>> 4);
            default: y = x + 2*ref_h1 - ((13*ref_h1) >>> 6) - ref_h2 + ((3*ref_h2) >>> 4);
        endcase
        if (y > 32767) y = 32767;
        if (y < -32768) y = -32768;
        ref_h2 = ref_h1;
        ref_h1 = y;
        return y;
    endfunction

    // Queue a header plus ndata bytes; fill<0 means pseudo-random data
    task automatic add_block(input int sh, input int f, input bit lp, input bit en,
                             input int ndata, input int fill);
        logic [7:0] h;
        h = {sh[3:0], f[1:0], lp, en};
        in_q.push_back(h);
        for (int k = 0; k < ndata; k++) begin
            int b;
            exp_t e;
            b = (fill < 0) ? next_byte() : fill;
            in_q.push_back(b[7:0]);
            e.s = model((b >> 4) & 15, sh, f);
            e.last = 0; e.stp = 0; e.lp = 0;
            exp_q.push_back(e);
            e.s = model(b & 15, sh, f);
            e.last = (k == 7);
            e.stp  = (k == 7) && en && !lp;
            e.lp   = (k == 7) && en && lp;
            exp_q.push_back(e);
        end
    endtask

    task automatic run(input int rdy_mode);
        bit   stalled = 0;
        int   held = 0;
        int   guard = 0;
        while ((in_q.size() > 0 || exp_q.size() > 0) && guard < 5000) begin
            guard++;
            @(negedge clk);
            cyc++;
            in_valid  = (in_q.size() > 0) && ((cyc % 5) != 3);
            in_data   = (in_q.size() > 0) ? in_q[0] : 8'h00;
            out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 7) < 3);
            #1;
            if (stalled) begin
                // R11: stalled sample held
                check(out_valid && int'($signed(out_sample)) == held, "R11 stall hold",
                      int'($signed(out_sample)), held);
            end
            stalled = out_valid && !out_ready;
            held    = int'($signed(out_sample));
            if (in_valid && in_ready) void'(in_q.pop_front());
            if (out_valid && out_ready) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check(0, "R1 extra sample", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(int'($signed(out_sample)) == e.s, "R3-R8 sample value",
                          int'($signed(out_sample)), e.s);
                    check(out_last == e.last, "R1 last marker", out_last, e.last);
                    check(out_stop == e.stp, "R9 stop flag", out_stop, e.stp);
                    check(out_loop == e.lp, "R9 loop flag", out_loop, e.lp);
                end
            end
        end
        @(negedge clk);
        in_valid  = 0;
        out_ready = 0;
        check(guard < 5000, "R1 stream drained", guard, 5000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(in_ready == 1 && out_valid == 0, "R11 reset state", {in_ready, out_valid}, 2);

        // R4 filter 0, R2 header decode, no flags
        add_block(0, 0, 0, 0, 8, -1);
        run(0);
        // R5 filter 1 with shift 4, stalled sink
        add_block(4, 1, 0, 0, 8, -1);
        run(1);
        // R6 filter 2, end+loop -> loop flag (R9)
        add_block(8, 2, 1, 1, 8, -1);
        run(0);
        // R7 filter 3, end only -> stop flag (R9)
        add_block(6, 3, 0, 1, 8, -1);
        run(1);
        // R9 loop bit without end bit: no flags
        add_block(2, 1, 1, 0, 8, -1);
        run(0);
        // R8 positive clamp then negative clamp; large shift
        add_block(12, 2, 0, 0, 8, 8'h77);
        add_block(12, 3, 0, 0, 8, 8'h88);
        add_block(15, 0, 0, 1, 8, 8'h7F);
        run(1);

        // R10: partial block, then restart
        add_block(3, 2, 0, 0, 3, -1);
        run(0);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        #1;
        check(in_ready == 1 && out_valid == 0, "R10 idle after restart",
              {in_ready, out_valid}, 2);
        ref_h1 = 0;
        ref_h2 = 0;
        add_block(5, 3, 1, 1, 8, -1);
        run(1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule